// File: doc/BRIEF.md
# Bit-Interleaved Four-Channel TDM Demultiplexer

This block takes a single high-rate serial bit stream (16.384 Mbit/s) in which four DS1 channels share each octet bit by bit. Every octet pairs one payload bit position with a partner bit, taken for channel 0, then 1, 2 and 3. It locks its bit counters to a one-clock frame-start pulse. It throws away the filler octets that pad each group, and rebuilds, per channel, the eight-bit payload of every timeslot, the four robbed-bit signaling flags and the per-frame framing bit.

A frame is 2048 bit times: eight groups of 32 octets. Of the 32 octets in a group, the first 24 carry data and the last 8 are filler. The 24 data octets cover three timeslots. Each timeslot takes eight octets, one for each payload bit position from 1 to 8. Recovered results come out as four parallel lanes, one lane per channel, so the lane position is the channel index. All four channels share one valid strobe and one timeslot index. The consumer hands each lane on to that channel's own framer.

Top module: `tdm_bitmux_demux`

## Requirements
- R1: From reset until the first `i_sync` pulse, `o_vld`, `o_fvld` and `o_slip` stay low whatever `i_dat` carries.
- R2: The bit sampled with `i_sync` high is frame bit 0. The frame is 2048 bits long: group g = bit/256, octet-in-group o = (bit mod 256)/8, bit-in-octet k = bit mod 8.
- R3: Octets 24 to 31 of every group are filler, and their contents have no effect on any output.
- R4: In data octet o, the payload bit position is (o mod 8)+1 and the timeslot is 3g + o/8. Even k carries the payload bit of channel k/2. Payload bit 1 lands in the MSB of the lane, and channel c occupies `o_pay[8c+7:8c]`.
- R5: Odd k carries the partner bit of channel k/2. For payload bit positions 5, 6, 7 and 8 the partner bits are signaling A, B, C and D, placed in `o_sig[4c+3]`, `[4c+2]`, `[4c+1]` and `[4c]`.
- R6: `o_vld` is high for exactly one clock. That clock follows the edge that samples the last bit (k = 7) of a timeslot's octet for payload bit 8, and `o_ts` (0..23) names that timeslot at the same time.
- R7: The partner of payload bit 1 in timeslot 0 is channel c's framing bit, shown on `o_fbit[c]`. `o_fvld` pulses for one clock after the last bit of that octet (frame bit 7) is sampled, and never coincides with `o_vld`.
- R8: Partner bits of payload bit positions 1 to 4 (other than the framing bit) are ignored and change no output.
- R9: An `i_sync` pulse at any bit other than the expected frame start, once locked, raises `o_slip` for one clock in the next cycle. Counting restarts with that bit as frame bit 0.
- R10: An `i_sync` pulse at the expected frame start leaves `o_slip` low.
- R11: Once locked, the block keeps counting across frame boundaries without further sync pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_sync | input | 1 | Frame-start pulse, high during frame bit 0 |
| i_dat | input | 1 | Interleaved serial data |
| o_vld | output | 1 | Timeslot result strobe |
| o_ts | output | 5 | Timeslot index 0..23 |
| o_pay | output | 32 | Payload octets, 8 bits per channel lane |
| o_sig | output | 16 | A/B/C/D signaling, 4 bits per channel lane |
| o_fvld | output | 1 | Framing-bit strobe |
| o_fbit | output | 4 | Framing bit per channel |
| o_slip | output | 1 | Misaligned sync pulse seen |

## Verification
Every result is registered once. The timeslot strobe, lanes and index appear in the cycle after the edge that samples the eighth octet's last bit. The framing-bit strobe follows frame bit 7 by one cycle, and `o_slip` follows the offending sync by one cycle. The bench drives each bit at the falling edge and computes the expected outputs for that bit from its own frame model. It compares them at the next falling edge, after the sampling rising edge. Filler and ignored partner bits are driven with varying values in some frames, and the unchanged lanes show they had no effect.

// File: rtl/tdm_demux_pkg.sv
`timescale 1ns/1ps
package tdm_demux_pkg;

  localparam int unsigned DMX_CH_N     = 4;   // interleaved channels
  localparam int unsigned DMX_PB_N     = 8;   // payload bits per timeslot
  localparam int unsigned DMX_SIG_N    = 4;   // robbed-bit signaling flags
  localparam int unsigned DMX_SLOTS    = 3;   // timeslots per group
  localparam int unsigned DMX_GRP_OCT  = 32;  // octets per group (data + filler)
  localparam int unsigned DMX_GROUPS   = 8;   // groups per frame

  typedef enum logic [1:0] {
    ROLE_SKIP = 2'd0,
    ROLE_PAY  = 2'd1,
    ROLE_SIG  = 2'd2,
    ROLE_FBIT = 2'd3
  } bit_role_e;

endpackage

// File: rtl/tdm_frame_counter.sv
`timescale 1ns/1ps
module tdm_frame_counter #(
  parameter int unsigned FRAME_BITS = 2048,
  localparam int unsigned IDX_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_sync,
  output logic [IDX_W-1:0] o_idx,
  output logic             o_live,
  output logic             o_slip,
  output logic             o_lock,
  output logic [IDX_W-1:0] o_cnt
);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;
  logic             cnt_en;

  always_comb begin
    o_idx  = i_sync ? '0 : cnt_q;
    o_live = i_sync | lock_q;
    cnt_en = o_live;
    cnt_d  = (o_idx == IDX_W'(FRAME_BITS - 1)) ? '0 : o_idx + 1'b1;
    lock_d = lock_q | i_sync;
    o_slip = i_sync & lock_q & (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign o_lock = lock_q;
  assign o_cnt  = cnt_q;

endmodule

// File: rtl/tdm_pos_decode.sv
`timescale 1ns/1ps
module tdm_pos_decode
  import tdm_demux_pkg::*;
#(
  parameter int unsigned CH_N     = 4,
  parameter int unsigned PB_N     = 8,
  parameter int unsigned SIG_N    = 4,
  parameter int unsigned SLOTS    = 3,
  parameter int unsigned GRP_OCT  = 32,
  parameter int unsigned GROUPS   = 8,
  localparam int unsigned OCT_BITS = 2 * CH_N,
  localparam int unsigned K_W      = $clog2(OCT_BITS),
  localparam int unsigned O_W      = $clog2(GRP_OCT),
  localparam int unsigned PB_W     = $clog2(PB_N),
  localparam int unsigned CH_W     = $clog2(CH_N),
  localparam int unsigned TS_N     = GROUPS * SLOTS,
  localparam int unsigned TS_W     = $clog2(TS_N),
  localparam int unsigned FRAME_BITS = GROUPS * GRP_OCT * OCT_BITS,
  localparam int unsigned IDX_W    = $clog2(FRAME_BITS),
  localparam int unsigned G_W      = IDX_W - K_W - O_W,
  localparam int unsigned DATA_OCT = SLOTS * PB_N,
  localparam int unsigned SIG_FIRST = PB_N - SIG_N
) (
  input  logic [IDX_W-1:0] i_idx,
  output bit_role_e        o_role,
  output logic [CH_W-1:0]  o_ch,
  output logic [PB_W-1:0]  o_pb,
  output logic [TS_W-1:0]  o_ts,
  output logic             o_emit_slot,
  output logic             o_emit_fbit
);

  logic [K_W-1:0] k;
  logic [O_W-1:0] oct;
  logic [G_W-1:0] grp;
  logic [O_W-1:0] tsl;
  logic           in_data;
  logic           last_bit;

  always_comb begin
    k        = i_idx[K_W-1:0];
    oct      = i_idx[K_W +: O_W];
    grp      = i_idx[IDX_W-1 -: G_W];
    tsl      = oct >> PB_W;
    in_data  = (oct < O_W'(DATA_OCT));
    last_bit = (k == K_W'(OCT_BITS - 1));
    o_pb     = oct[PB_W-1:0];
    o_ch     = k[K_W-1:1];
    o_ts     = TS_W'(grp) * TS_W'(SLOTS) + TS_W'(tsl);

    if (!in_data)                          o_role = ROLE_SKIP;
    else if (!k[0])                        o_role = ROLE_PAY;
    else if (o_pb >= PB_W'(SIG_FIRST))     o_role = ROLE_SIG;
    else if (o_pb == '0 && o_ts == '0)     o_role = ROLE_FBIT;
    else                                   o_role = ROLE_SKIP;

    o_emit_slot = in_data & last_bit & (o_pb == PB_W'(PB_N - 1));
    o_emit_fbit = in_data & last_bit & (o_pb == '0) & (o_ts == '0);
  end

endmodule

// File: rtl/tdm_lane_acc.sv
`timescale 1ns/1ps
module tdm_lane_acc
  import tdm_demux_pkg::*;
#(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned PB_N  = 8,
  parameter int unsigned SIG_N = 4,
  localparam int unsigned PB_W  = $clog2(PB_N),
  localparam int unsigned SIG_W = $clog2(SIG_N),
  localparam int unsigned CH_W  = $clog2(CH_N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  i_en,
  input  logic                  i_dat,
  input  bit_role_e             i_role,
  input  logic [CH_W-1:0]       i_ch,
  input  logic [PB_W-1:0]       i_pb,
  output logic [CH_N*PB_N-1:0]  o_pay_nx,
  output logic [CH_N*SIG_N-1:0] o_sig_nx,
  output logic [CH_N-1:0]       o_fbit_nx
);

  logic [PB_W-1:0] rev_pb;
  assign rev_pb = PB_W'(PB_N - 1) - i_pb;

  for (genvar gi = 0; gi < CH_N; gi++) begin : g_lane
    logic [PB_N-1:0]  pay_q, pay_n;
    logic [SIG_N-1:0] sig_q, sig_n;
    logic             fb_q, fb_n;
    logic             sel;

    always_comb begin
      sel   = i_en & (i_ch == CH_W'(gi));
      pay_n = pay_q;
      sig_n = sig_q;
      fb_n  = fb_q;
      if (sel) begin
        case (i_role)
          ROLE_PAY:  pay_n[rev_pb]          = i_dat;
          ROLE_SIG:  sig_n[SIG_W'(rev_pb)]  = i_dat;
          ROLE_FBIT: fb_n                   = i_dat;
          default:   ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pay_q <= '0;
        sig_q <= '0;
        fb_q  <= 1'b0;
      end else if (sel) begin
        pay_q <= pay_n;
        sig_q <= sig_n;
        fb_q  <= fb_n;
      end
    end

    assign o_pay_nx[gi*PB_N +: PB_N]   = pay_n;
    assign o_sig_nx[gi*SIG_N +: SIG_N] = sig_n;
    assign o_fbit_nx[gi]               = fb_n;
  end

endmodule

// File: rtl/tdm_bitmux_demux.sv
`timescale 1ns/1ps
module tdm_bitmux_demux
  import tdm_demux_pkg::*;
#(
  parameter int unsigned CH_N    = DMX_CH_N,
  parameter int unsigned PB_N    = DMX_PB_N,
  parameter int unsigned SIG_N   = DMX_SIG_N,
  parameter int unsigned SLOTS   = DMX_SLOTS,
  parameter int unsigned GRP_OCT = DMX_GRP_OCT,
  parameter int unsigned GROUPS  = DMX_GROUPS,
  localparam int unsigned TS_N   = GROUPS * SLOTS,
  localparam int unsigned TS_W   = $clog2(TS_N),
  localparam int unsigned FRAME_BITS = GROUPS * GRP_OCT * 2 * CH_N,
  localparam int unsigned IDX_W  = $clog2(FRAME_BITS),
  localparam int unsigned PB_W   = $clog2(PB_N),
  localparam int unsigned CH_W   = $clog2(CH_N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  i_sync,
  input  logic                  i_dat,
  output logic                  o_vld,
  output logic [TS_W-1:0]       o_ts,
  output logic [CH_N*PB_N-1:0]  o_pay,
  output logic [CH_N*SIG_N-1:0] o_sig,
  output logic                  o_fvld,
  output logic [CH_N-1:0]       o_fbit,
  output logic                  o_slip
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [IDX_W-1:0] idx, frm_cnt;
  logic             live, slip_c, frm_locked;

  tdm_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .i_sync (i_sync),
    .o_idx  (idx),
    .o_live (live),
    .o_slip (slip_c),
    .o_lock (frm_locked),
    .o_cnt  (frm_cnt)
  );

  bit_role_e       role;
  logic [CH_W-1:0] dch;
  logic [PB_W-1:0] dpb;
  logic [TS_W-1:0] dts;
  logic            emit_slot, emit_fbit;

  tdm_pos_decode #(
    .CH_N(CH_N), .PB_N(PB_N), .SIG_N(SIG_N),
    .SLOTS(SLOTS), .GRP_OCT(GRP_OCT), .GROUPS(GROUPS)
  ) u_dec (
    .i_idx       (idx),
    .o_role      (role),
    .o_ch        (dch),
    .o_pb        (dpb),
    .o_ts        (dts),
    .o_emit_slot (emit_slot),
    .o_emit_fbit (emit_fbit)
  );

  logic [CH_N*PB_N-1:0]  pay_nx;
  logic [CH_N*SIG_N-1:0] sig_nx;
  logic [CH_N-1:0]       fbit_nx;

  tdm_lane_acc #(.CH_N(CH_N), .PB_N(PB_N), .SIG_N(SIG_N)) u_acc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .i_en      (live),
    .i_dat     (i_dat),
    .i_role    (role),
    .i_ch      (dch),
    .i_pb      (dpb),
    .o_pay_nx  (pay_nx),
    .o_sig_nx  (sig_nx),
    .o_fbit_nx (fbit_nx)
  );

  // output stage: next-state logic
  logic vld_d, fvld_d, slip_d;

  always_comb begin
    vld_d  = live & emit_slot;
    fvld_d = live & emit_fbit;
    slip_d = slip_c;
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      o_vld  <= 1'b0;
      o_fvld <= 1'b0;
      o_slip <= 1'b0;
      o_ts   <= '0;
      o_pay  <= '0;
      o_sig  <= '0;
      o_fbit <= '0;
    end else begin
      o_vld  <= vld_d;
      o_fvld <= fvld_d;
      o_slip <= slip_d;
      if (vld_d) begin
        o_ts  <= dts;
        o_pay <= pay_nx;
        o_sig <= sig_nx;
      end
      if (fvld_d) o_fbit <= fbit_nx;
    end
  end

endmodule

// File: rtl/tdm_bitmux_demux_chk.sv
`timescale 1ns/1ps
module tdm_bitmux_demux_chk #(
  parameter int unsigned TS_N  = 24,
  parameter int unsigned TS_W  = 5,
  parameter int unsigned IDX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_sync,
  input logic             o_vld,
  input logic [TS_W-1:0]  o_ts,
  input logic             o_fvld,
  input logic             o_slip,
  input logic             lock,
  input logic [IDX_W-1:0] cnt
);

  AST_QUIET_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> (!o_vld && !o_fvld)); // R1

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> (o_ts < TS_W'(TS_N))); // R6

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |=> !o_vld); // R6

  AST_FBIT_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_vld && o_fvld)); // R7

  AST_SLIP_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (i_sync && lock && cnt != '0) |=> o_slip); // R9

  AST_SLIP_ONLY_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !i_sync |=> !o_slip); // R9

  AST_ALIGNED_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (i_sync && cnt == '0) |=> !o_slip); // R10

endmodule

bind tdm_bitmux_demux tdm_bitmux_demux_chk #(
  .TS_N(TS_N), .TS_W(TS_W), .IDX_W(IDX_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .i_sync (i_sync),
  .o_vld  (o_vld),
  .o_ts   (o_ts),
  .o_fvld (o_fvld),
  .o_slip (o_slip),
  .lock   (frm_locked),
  .cnt    (frm_cnt)
);

// File: tb/sim_tdm_bitmux_demux.sv
`timescale 1ns/1ps
module sim_tdm_bitmux_demux;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, i_sync, i_dat;
  logic        o_vld, o_fvld, o_slip;
  logic [4:0]  o_ts;
  logic [31:0] o_pay;
  logic [15:0] o_sig;
  logic [3:0]  o_fbit;

  tdm_bitmux_demux u0 (
    .clk(clk), .rst_n(rst_n), .i_sync(i_sync), .i_dat(i_dat),
    .o_vld(o_vld), .o_ts(o_ts), .o_pay(o_pay), .o_sig(o_sig),
    .o_fvld(o_fvld), .o_fbit(o_fbit), .o_slip(o_slip)
  );

  int checks = 0, errors = 0, strobes = 0;
  int mpos = 0;
  bit seen = 0, done = 0;
  int seed_cur = 0;
  bit noisy = 0;
  string tag_pay = "R4", tag_sig = "R5";

  logic        ex_vld = 0, ex_fvld = 0, ex_slip = 0, ex_alsync = 0;
  logic [4:0]  ex_ts = 0;
  logic [31:0] ex_pay = 0;
  logic [15:0] ex_sig = 0;
  logic [3:0]  ex_fbit = 0;

  function automatic logic [7:0] pay_of(int ch, int ts, int sd);
    return 8'((ch * 37 + ts * 11 + sd * 53 + (ch ^ ts)) & 255);
  endfunction
  function automatic logic [3:0] sig_of(int ch, int ts, int sd);
    return 4'((ch * 5 + ts * 3 + sd * 7) & 15);
  endfunction
  function automatic logic fb_of(int ch, int sd);
    return 1'(((sd >> ch) ^ ch) & 1);
  endfunction

  function automatic logic bit_at(int p, int sd, bit nz);
    int g = p / 256, o = (p % 256) / 8, k = p % 8;
    int pb = o % 8, ts = 3 * g + o / 8, ch = k / 2;
    logic [7:0] pv;
    logic [3:0] sv;
    if (o >= 24) return nz ? 1'(((p >> 1) ^ p) & 1) : 1'b0;
    if (k % 2 == 0) begin
      pv = pay_of(ch, ts, sd);
      return pv[7 - pb];
    end
    if (pb >= 4) begin
      sv = sig_of(ch, ts, sd);
      return sv[7 - pb];
    end
    if (pb == 0 && ts == 0) return fb_of(ch, sd);
    return nz ? 1'((p >> 2) & 1) : 1'b0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_prev();
    if (o_vld === 1'b1 || o_fvld === 1'b1) strobes++;
    if (ex_vld) begin
      chk(o_vld === 1'b1, "R6", "slot strobe", 32'(o_vld), 1);
      chk(o_ts === ex_ts, "R2 R6", "slot index", 32'(o_ts), 32'(ex_ts));
      chk(o_pay === ex_pay, tag_pay, "payload lanes", o_pay, ex_pay);
      chk(o_sig === ex_sig, tag_sig, "signaling lanes", 32'(o_sig), 32'(ex_sig));
    end else if (o_vld !== 1'b0) chk(0, "R6", "stray slot strobe", 32'(o_vld), 0);
    if (ex_fvld) begin
      chk(o_fvld === 1'b1, "R7", "fbit strobe", 32'(o_fvld), 1);
      chk(o_fbit === ex_fbit, "R7", "fbit lanes", 32'(o_fbit), 32'(ex_fbit));
    end else if (o_fvld !== 1'b0) chk(0, "R7", "stray fbit strobe", 32'(o_fvld), 0);
    if (ex_slip)        chk(o_slip === 1'b1, "R9", "slip flag", 32'(o_slip), 1);
    else if (ex_alsync) chk(o_slip === 1'b0, "R10", "slip on aligned sync", 32'(o_slip), 0);
    else if (o_slip !== 1'b0) chk(0, "R9", "stray slip", 32'(o_slip), 0);
  endtask

  task automatic drive_bit(int p, bit sync);
    int q, g, o, k, pb, ts;
    @(negedge clk);
    compare_prev();
    i_sync    = sync;
    i_dat     = bit_at(p, seed_cur, noisy);
    ex_slip   = sync && seen && mpos != 0;
    ex_alsync = sync && seen && mpos == 0;
    ex_vld    = 0;
    ex_fvld   = 0;
    q = sync ? 0 : mpos;
    if (sync) seen = 1;
    if (seen) begin
      g = q / 256; o = (q % 256) / 8; k = q % 8; pb = o % 8; ts = 3 * g + o / 8;
      if (o < 24 && k == 7 && pb == 7) begin
        ex_vld = 1;
        ex_ts  = 5'(ts);
        for (int c = 0; c < 4; c++) begin
          ex_pay[8*c +: 8] = pay_of(c, ts, seed_cur);
          ex_sig[4*c +: 4] = sig_of(c, ts, seed_cur);
        end
      end
      if (o < 24 && k == 7 && pb == 0 && ts == 0) begin
        ex_fvld = 1;
        for (int c = 0; c < 4; c++) ex_fbit[c] = fb_of(c, seed_cur);
      end
      mpos = (q + 1) % 2048;
    end
  endtask

  task automatic run_span(int first, int n, bit sync_first);
    for (int i = 0; i < n; i++) drive_bit((first + i) % 2048, sync_first && i == 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; i_sync = 1'b0; i_dat = 1'b0;
    repeat (3) @(negedge clk);
    chk(o_vld === 1'b0 && o_fvld === 1'b0 && o_slip === 1'b0, "R1", "outputs in reset",
        {29'd0, o_vld, o_fvld, o_slip}, 0);
    rst_n = 1'b1;
    run_span(0, 4, 0);
  endtask

  task automatic t_presync();
    strobes = 0; noisy = 1; seed_cur = 9;
    run_span(100, 300, 0);
    chk(strobes == 0, "R1", "strobes before sync", 32'(strobes), 0);
  endtask

  task automatic t_first_frame();
    strobes = 0; noisy = 0; seed_cur = 1; tag_pay = "R4"; tag_sig = "R5";
    run_span(0, 2048, 1);
    chk(strobes == 25, "R2", "strobes in first frame", 32'(strobes), 25);
  endtask

  task automatic t_free_run_noisy();
    strobes = 0; noisy = 1; seed_cur = 2;
    tag_pay = "R4 R3 R8 R11"; tag_sig = "R5 R3 R8 R11";
    run_span(0, 2048, 0);
    chk(strobes == 25, "R11", "strobes without sync", 32'(strobes), 25);
  endtask

  task automatic t_aligned_sync();
    noisy = 1; seed_cur = 3; tag_pay = "R4 R10"; tag_sig = "R5 R10";
    run_span(0, 2048, 1);
  endtask

  task automatic t_midframe_sync();
    noisy = 0; seed_cur = 4; tag_pay = "R4"; tag_sig = "R5";
    run_span(0, 700, 0);
    strobes = 0; seed_cur = 5; tag_pay = "R4 R9"; tag_sig = "R5 R9";
    run_span(0, 2048, 1);
    chk(strobes == 25, "R9", "strobes after realign", 32'(strobes), 25);
  endtask

  initial begin
    t_reset();
    t_presync();
    t_first_frame();
    t_free_run_noisy();
    t_aligned_sync();
    t_midframe_sync();
    @(negedge clk);
    compare_prev();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      chk(0, "WATCHDOG", "run did not complete", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule